// File: doc/BRIEF.md
# ALU Status Flags and Branch Condition Unit

This block sits beside an integer ALU. When the ALU finishes an add or a subtract, it passes the operands, the result and the carry (or borrow) out of bit 7 and bit 15 to this block. The block then derives six arithmetic status flags and loads them into a 16-bit flag word. That word also holds three control bits: single-step, interrupt enable and direction. Software changes these bits only through dedicated set and clear strobes.

A width select chooses between byte and word operation. In byte operation, the carry, zero, sign and overflow flags are taken at bit 7. In word operation they are taken at bit 15. The stored flags and a 4-bit condition code drive a combinational branch-taken output. The condition set covers single-flag tests, unsigned ordering built from carry and zero, and signed ordering built from the sign/overflow mismatch and zero. A separate count mode ignores the flags and reports whether a loop counter is zero.

Top module: `flag_cond_unit`

## Requirements
- R1: The flag word places carry at bit 0, parity at bit 2, nibble carry at bit 4, zero at bit 6, sign at bit 7, single-step at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. Bits 1, 3, 5 and 12 to 15 always read 0.
- R2: While `rst_n` is low, the whole flag word is 0.
- R3: The six arithmetic flags load on the rising clock edge at which `upd_en_i` is 1. Otherwise they hold their value.
- R4: Carry takes `cy_hi_i` when `wide_i`=1 and `cy_lo_i` when `wide_i`=0. The caller supplies the carry out for an add (`sub_i`=0) and the borrow out for a subtract (`sub_i`=1).
- R5: Zero is set when the result is zero, and sign equals the result's top bit. Both use bits 15..0 when `wide_i`=1 and bits 7..0 when `wide_i`=0, so bits 15..8 are ignored in byte operation.
- R6: Parity is set when bits 7..0 of the result hold an even number of ones.
- R7: Nibble carry is the carry (add) or borrow (subtract) from bit 3 into bit 4.
- R8: Overflow is set on two's-complement overflow at the selected width, for both add and subtract.
- R9: A 1 on bit k of `ctl_set_i` sets control bit 8+k on the next edge, and a 1 on bit k of `ctl_clr_i` clears it. Clear wins over set. `upd_en_i` never changes the control bits, and the strobes never change the arithmetic flags.
- R10: Condition codes 0/1 test overflow set/clear, 2/3 test carry set/clear, 4/5 test zero set/clear, 8/9 test sign set/clear and 10/11 test parity set/clear.
- R11: Unsigned ordering: code 6 (below or equal) is taken when carry or zero is 1, and code 7 (above) when both are 0.
- R12: Signed ordering: code 12 (less) is taken when sign differs from overflow, and code 13 when they match. Code 14 (less or equal) is taken when sign differs from overflow or zero is 1, and code 15 (greater) otherwise.
- R13: With `cnt_mode_i`=1, `taken_o` is 1 exactly when `count_i` is zero, whatever `cond_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en_i | input | 1 | Load arithmetic flags this cycle |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| wide_i | input | 1 | 1 = word (bit 15), 0 = byte (bit 7) |
| opa_i | input | 16 | First ALU operand |
| opb_i | input | 16 | Second ALU operand |
| res_i | input | 16 | ALU result |
| cy_lo_i | input | 1 | Carry/borrow out of bit 7 |
| cy_hi_i | input | 1 | Carry/borrow out of bit 15 |
| ctl_set_i | input | 3 | Set strobes: step, irq enable, direction |
| ctl_clr_i | input | 3 | Clear strobes, same order |
| cond_i | input | 4 | Branch condition code |
| cnt_mode_i | input | 1 | Evaluate counter-zero instead of flags |
| count_i | input | 16 | Loop counter value |
| flags_o | output | 16 | Stored flag word |
| taken_o | output | 1 | Branch condition result |

## Verification
On every cycle, the assertions check that the reserved bits stay zero and that the arithmetic flags hold whenever no update is requested. They also check the width selection of carry and sign, the zero flag for a zero word result, the priority and isolation of the control strobes, and the counter-zero override. Only the bench's scenarios can show that parity, nibble carry and overflow match true arithmetic across many operand pairs. The same holds for the byte/word split in overflow. The bench also shows that every one of the sixteen condition codes gives the answer an independent signed or unsigned comparison of the operands would give.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  localparam int FLAG_W   = 16;
  localparam int NCTL     = 3;
  localparam int CF_BIT   = 0;
  localparam int PF_BIT   = 2;
  localparam int AF_BIT   = 4;
  localparam int ZF_BIT   = 6;
  localparam int SF_BIT   = 7;
  localparam int CTL_BASE = 8;
  localparam int OF_BIT   = 11;

  localparam logic [FLAG_W-1:0] ARITH_MASK = 16'h08D5;
  localparam logic [FLAG_W-1:0] CTL_MASK   = 16'h0700;
  localparam logic [FLAG_W-1:0] RSVD_MASK  = ~(ARITH_MASK | CTL_MASK);

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic nib;
    logic par;
    logic cry;
  } arith_t;

  typedef enum logic [3:0] {
    CC_OV  = 4'd0,  CC_NOV = 4'd1,
    CC_BLW = 4'd2,  CC_NBL = 4'd3,
    CC_EQ  = 4'd4,  CC_NE  = 4'd5,
    CC_BE  = 4'd6,  CC_ABV = 4'd7,
    CC_NEG = 4'd8,  CC_POS = 4'd9,
    CC_PE  = 4'd10, CC_PO  = 4'd11,
    CC_LT  = 4'd12, CC_GE  = 4'd13,
    CC_LE  = 4'd14, CC_GT  = 4'd15
  } cc_e;

  // Even number of ones in the low byte.
  function automatic logic even_par(input logic [FLAG_W-1:0] r);
    return ~(^r[7:0]);
  endfunction

  // Carry or borrow between bit 3 and bit 4 recovered from the sum bit.
  function automatic logic nibble_cross(input logic [FLAG_W-1:0] a,
                                        input logic [FLAG_W-1:0] b,
                                        input logic [FLAG_W-1:0] r);
    return a[4] ^ b[4] ^ r[4];
  endfunction

  // Two's-complement overflow from operand and result sign bits.
  function automatic logic sign_ovf(input logic sub, input logic sa,
                                    input logic sb, input logic sr);
    logic same_in;
    same_in = sub ? (sa != sb) : (sa == sb);
    return same_in && (sr != sa);
  endfunction
endpackage

// File: rtl/flag_gen.sv
module flag_gen
  import flagu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          sub_i,
  input  logic          wide_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] res_i,
  input  logic          cy_lo_i,
  input  logic          cy_hi_i,
  output arith_t        arith_o,
  output logic          res_zero_o
);
  localparam int HW = DW / 2;

  logic msb_a, msb_b, msb_r;

  always_comb begin
    msb_a = wide_i ? opa_i[DW-1] : opa_i[HW-1];
    msb_b = wide_i ? opb_i[DW-1] : opb_i[HW-1];
    msb_r = wide_i ? res_i[DW-1] : res_i[HW-1];
    res_zero_o = wide_i ? (res_i == '0) : (res_i[HW-1:0] == '0);
  end

  always_comb begin
    arith_o.cry = wide_i ? cy_hi_i : cy_lo_i;
    arith_o.par = even_par(res_i);
    arith_o.nib = nibble_cross(opa_i, opb_i, res_i);
    arith_o.zro = res_zero_o;
    arith_o.sgn = msb_r;
    arith_o.ovf = sign_ovf(sub_i, msb_a, msb_b, msb_r);
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flagu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en_i,
  input  arith_t            arith_i,
  input  logic [NCTL-1:0]   ctl_set_i,
  input  logic [NCTL-1:0]   ctl_clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  arith_t          arith_q;
  logic [NCTL-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        arith_q <= '0;
    else if (upd_en_i) arith_q <= arith_i;
  end

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n)            ctl_q[k] <= 1'b0;
      else if (ctl_clr_i[k]) ctl_q[k] <= 1'b0;
      else if (ctl_set_i[k]) ctl_q[k] <= 1'b1;
    end
  end

  always_comb begin
    flags_o = '0;
    flags_o[CF_BIT] = arith_q.cry;
    flags_o[PF_BIT] = arith_q.par;
    flags_o[AF_BIT] = arith_q.nib;
    flags_o[ZF_BIT] = arith_q.zro;
    flags_o[SF_BIT] = arith_q.sgn;
    flags_o[OF_BIT] = arith_q.ovf;
    flags_o[CTL_BASE +: NCTL] = ctl_q;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flagu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [3:0]        cond_i,
  input  logic              cnt_mode_i,
  input  logic [DW-1:0]     count_i,
  output logic              taken_o,
  output logic              cnt_zero_o
);
  logic cf, zf, sf, of, pf, sign_mis, base_hit;

  always_comb begin
    cf = flags_i[CF_BIT];
    zf = flags_i[ZF_BIT];
    sf = flags_i[SF_BIT];
    of = flags_i[OF_BIT];
    pf = flags_i[PF_BIT];
    sign_mis = sf ^ of;
    cnt_zero_o = (count_i == '0);
    // Even codes test the positive sense; odd codes invert it.
    unique case (cond_i[3:1])
      3'd0:    base_hit = of;
      3'd1:    base_hit = cf;
      3'd2:    base_hit = zf;
      3'd3:    base_hit = cf | zf;
      3'd4:    base_hit = sf;
      3'd5:    base_hit = pf;
      3'd6:    base_hit = sign_mis;
      default: base_hit = sign_mis | zf;
    endcase
    taken_o = cnt_mode_i ? cnt_zero_o : (base_hit ^ cond_i[0]);
  end
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flagu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en_i,
  input  logic              sub_i,
  input  logic              wide_i,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  input  logic [DW-1:0]     res_i,
  input  logic              cy_lo_i,
  input  logic              cy_hi_i,
  input  logic [NCTL-1:0]   ctl_set_i,
  input  logic [NCTL-1:0]   ctl_clr_i,
  input  logic [3:0]        cond_i,
  input  logic              cnt_mode_i,
  input  logic [DW-1:0]     count_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              taken_o
);
  arith_t arith_nxt;
  logic   res_zero;
  logic   cnt_zero;

  flag_gen #(.DW(DW)) u_gen (
    .sub_i      (sub_i),
    .wide_i     (wide_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .res_i      (res_i),
    .cy_lo_i    (cy_lo_i),
    .cy_hi_i    (cy_hi_i),
    .arith_o    (arith_nxt),
    .res_zero_o (res_zero)
  );

  flag_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en_i  (upd_en_i),
    .arith_i   (arith_nxt),
    .ctl_set_i (ctl_set_i),
    .ctl_clr_i (ctl_clr_i),
    .flags_o   (flags_o)
  );

  cond_eval #(.DW(DW)) u_cond (
    .flags_i    (flags_o),
    .cond_i     (cond_i),
    .cnt_mode_i (cnt_mode_i),
    .count_i    (count_i),
    .taken_o    (taken_o),
    .cnt_zero_o (cnt_zero)
  );
endmodule

// File: rtl/flag_cond_unit_chk.sv
module flag_cond_unit_chk
  import flagu_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_en_i,
  input logic              wide_i,
  input logic [DW-1:0]     res_i,
  input logic              cy_lo_i,
  input logic              cy_hi_i,
  input logic [NCTL-1:0]   ctl_set_i,
  input logic [NCTL-1:0]   ctl_clr_i,
  input logic              cnt_mode_i,
  input logic [DW-1:0]     count_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              taken_o
);
  localparam int HW = DW / 2;

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & RSVD_MASK) == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en_i |=> $stable(flags_o & ARITH_MASK));

  p_carry_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flags_o[CF_BIT] == $past(wide_i ? cy_hi_i : cy_lo_i));

  p_sign_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flags_o[SF_BIT] == $past(wide_i ? res_i[DW-1] : res_i[HW-1]));

  p_zero_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && wide_i && res_i == '0) |=> flags_o[ZF_BIT]);

  p_ctl_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_clr_i) |=> (flags_o[CTL_BASE +: NCTL] & $past(ctl_clr_i)) == '0);

  p_ctl_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ctl_set_i & ~ctl_clr_i)) |=>
      (flags_o[CTL_BASE +: NCTL] & $past(ctl_set_i & ~ctl_clr_i))
        == $past(ctl_set_i & ~ctl_clr_i));

  p_ctl_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set_i == '0 && ctl_clr_i == '0) |=> $stable(flags_o[CTL_BASE +: NCTL]));

  p_count_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_mode_i |-> (taken_o == (count_i == '0)));
endmodule

bind flag_cond_unit flag_cond_unit_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_en_i   (upd_en_i),
  .wide_i     (wide_i),
  .res_i      (res_i),
  .cy_lo_i    (cy_lo_i),
  .cy_hi_i    (cy_hi_i),
  .ctl_set_i  (ctl_set_i),
  .ctl_clr_i  (ctl_clr_i),
  .cnt_mode_i (cnt_mode_i),
  .count_i    (count_i),
  .flags_o    (flags_o),
  .taken_o    (taken_o)
);

// File: tb/flag_cond_unit_tb.sv
module flag_cond_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en_i = 1'b0, sub_i = 1'b0, wide_i = 1'b1;
  logic [15:0] opa_i = '0, opb_i = '0, res_i = '0;
  logic        cy_lo_i = 1'b0, cy_hi_i = 1'b0;
  logic [2:0]  ctl_set_i = '0, ctl_clr_i = '0;
  logic [3:0]  cond_i = '0;
  logic        cnt_mode_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [15:0] flags_o;
  logic        taken_o;

  int n_run = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flag_cond_unit u_dut (.*);

  // {wide, sub, a, b}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h7FFF, 16'h0001},
    {1'b1, 1'b0, 16'hFFFF, 16'h0001},
    {1'b1, 1'b1, 16'h0005, 16'h0007},
    {1'b1, 1'b1, 16'h8000, 16'h0001},
    {1'b1, 1'b1, 16'h1234, 16'h1234},
    {1'b1, 1'b1, 16'h0007, 16'h0005},
    {1'b0, 1'b0, 16'h0080, 16'h0080},
    {1'b0, 1'b1, 16'h0010, 16'h0001},
    {1'b0, 1'b1, 16'h0003, 16'h0081},
    {1'b0, 1'b0, 16'h0033, 16'h0044},
    {1'b1, 1'b1, 16'hFFFE, 16'hFFFF},
    {1'b0, 1'b1, 16'h12FF, 16'h3401}
  };

  // Model state for the last loaded operation.
  logic [15:0] exp_flags;
  int m_ua, m_ub, m_sa, m_sb;
  logic m_sub;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent arithmetic model: integer sums and range checks.
  task automatic model_and_drive(input logic w, input logic s,
                                 input logic [15:0] a, input logic [15:0] b);
    int lim, ur, sr, maxs;
    logic [31:0] urv;
    logic cy, ov, af, zf, sf, pf;
    lim  = w ? 65536 : 256;
    maxs = w ? 32767 : 127;
    m_ua = w ? int'(a) : int'(a[7:0]);
    m_ub = w ? int'(b) : int'(b[7:0]);
    m_sa = w ? int'($signed(a)) : int'($signed(a[7:0]));
    m_sb = w ? int'($signed(b)) : int'($signed(b[7:0]));
    m_sub = s;
    ur = s ? m_ua - m_ub : m_ua + m_ub;
    sr = s ? m_sa - m_sb : m_sa + m_sb;
    cy = s ? (ur < 0) : (ur >= lim);
    ov = (sr > maxs) || (sr < -maxs - 1);
    af = s ? ((m_ua & 15) < (m_ub & 15)) : (((m_ua & 15) + (m_ub & 15)) > 15);
    urv = ur;
    zf = w ? (urv[15:0] == 0) : (urv[7:0] == 0);
    sf = w ? urv[15] : urv[7];
    pf = ($countones(urv[7:0]) % 2) == 0;
    exp_flags = '0;
    exp_flags[0] = cy; exp_flags[2] = pf; exp_flags[4] = af;
    exp_flags[6] = zf; exp_flags[7] = sf; exp_flags[11] = ov;
    wide_i = w; sub_i = s; opa_i = a; opb_i = b;
    res_i = w ? urv[15:0] : {8'hA5, urv[7:0]};
    cy_hi_i = w ? cy : ~cy;
    cy_lo_i = w ? ~cy : cy;
  endtask

  function automatic logic exp_cc(input int c, input logic [15:0] f);
    logic cf, zf, sf, of, pf, lt_u, eq, lt_s;
    cf = f[0]; pf = f[2]; zf = f[6]; sf = f[7]; of = f[11];
    lt_u = m_ua < m_ub; eq = m_ua == m_ub; lt_s = m_sa < m_sb;
    case (c)
      0: return of;
      1: return !of;
      2: return m_sub ? lt_u : cf;
      3: return m_sub ? !lt_u : !cf;
      4: return zf;
      5: return !zf;
      6: return m_sub ? (lt_u || eq) : (cf || zf);
      7: return m_sub ? !(lt_u || eq) : !(cf || zf);
      8: return sf;
      9: return !sf;
      10: return pf;
      11: return !pf;
      12: return m_sub ? lt_s : (sf != of);
      13: return m_sub ? !lt_s : (sf == of);
      14: return m_sub ? (lt_s || eq) : ((sf != of) || zf);
      default: return m_sub ? !(lt_s || eq) : !((sf != of) || zf);
    endcase
  endfunction

  task automatic check_all_cc(input logic [15:0] f);
    for (int c = 0; c < 16; c++) begin
      cond_i = 4'(c);
      #1;
      if (c == 2 || c == 3 || c == 6 || c == 7)
        check("R11 unsigned condition", {15'd0, taken_o}, {15'd0, exp_cc(c, f)});
      else if (c >= 12)
        check("R12 signed condition", {15'd0, taken_o}, {15'd0, exp_cc(c, f)});
      else
        check("R10 flag condition", {15'd0, taken_o}, {15'd0, exp_cc(c, f)});
    end
  endtask

  task automatic load_op(input logic w, input logic s, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    model_and_drive(w, s, a, b);
    upd_en_i = 1'b1;
    @(negedge clk);
    upd_en_i = 1'b0;
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R2 reset flags", flags_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 flags after reset release", flags_o, 16'h0000);

    // Table walk: R1 R4 R5 R6 R7 R8 plus every condition code.
    for (int i = 0; i < NV; i++) begin
      load_op(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
      check($sformatf("R4-R8 flags vec%0d", i), flags_o, exp_flags);
      check("R1 reserved bits", flags_o & 16'hF02A, 16'h0000);
      check_all_cc(exp_flags);
    end

    // R3: no update when upd_en_i is low, inputs changed.
    load_op(1'b1, 1'b0, 16'h7FFF, 16'h0001);
    held = flags_o;
    @(negedge clk);
    model_and_drive(1'b1, 1'b1, 16'h0000, 16'h0000);
    repeat (2) @(negedge clk);
    check("R3 hold without update", flags_o, held);

    // R9: set all control bits without update.
    ctl_set_i = 3'b111;
    @(negedge clk);
    ctl_set_i = 3'b000;
    check("R9 control set", flags_o, held | 16'h0700);
    check("R1 reserved with all bits", flags_o & 16'hF02A, 16'h0000);
    // R9: clear wins over set on interrupt enable.
    ctl_set_i = 3'b010; ctl_clr_i = 3'b010;
    @(negedge clk);
    ctl_set_i = '0; ctl_clr_i = '0;
    check("R9 clear priority", flags_o, held | 16'h0500);
    // R9: arithmetic update leaves control bits alone.
    load_op(1'b1, 1'b1, 16'h1234, 16'h1234);
    check("R9 update keeps control", flags_o, exp_flags | 16'h0500);
    ctl_clr_i = 3'b111;
    @(negedge clk);
    ctl_clr_i = '0;
    check("R9 control clear", flags_o, exp_flags);

    // R5: byte mode ignores upper result bits for zero.
    load_op(1'b0, 1'b1, 16'h7755, 16'h1155);
    check("R5 byte zero ignores upper", flags_o, exp_flags);
    check("R5 zero flag set", {15'd0, flags_o[6]}, 16'h0001);

    // R13: count mode overrides the condition.
    cnt_mode_i = 1'b1; cond_i = 4'd5; count_i = 16'h0000;
    #1 check("R13 count zero taken", {15'd0, taken_o}, 16'h0001);
    cond_i = 4'd4; count_i = 16'h0100;
    #1 check("R13 count nonzero not taken", {15'd0, taken_o}, 16'h0000);
    count_i = 16'h0001;
    #1 check("R13 count one not taken", {15'd0, taken_o}, 16'h0000);
    cnt_mode_i = 1'b0;

    // R2: reset mid-run clears everything.
    ctl_set_i = 3'b101;
    @(negedge clk);
    ctl_set_i = '0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset mid-run", flags_o, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule